// File: doc/BRIEF.md
# Dual-Pumped Three-Write Four-Read Register File

This block is the integer register file for a two-issue, five-stage core. On every core cycle it accepts three write requests (enable, register number, data) and four read requests (register number). It returns four read words. Storage is a single array with only two write ports and two read ports. The array runs on a clock at twice the core rate, so each physical port is used twice per core cycle. No part of the storage is duplicated.

A core cycle is two periods of `clk2x`. The first rising edge after reset release opens core cycle zero. Every later pair of edges is one core cycle, made of an A edge followed by a B edge. At the A edge the block samples all core-level inputs, and write ports 0 and 1 commit through the two physical write ports. At the B edge write port 2 commits. At that same B edge, read ports 0 and 1 are taken from the array with a forward path from port 2, and read ports 2 and 3 are read at the following A edge. All four read words are presented together at the A edge that ends the core cycle and stay there for one full core cycle. Each read therefore returns the register state after all three writes of its own core cycle.

Top module: `pumped_regfile`

## Requirements
- R1: With default parameters the file holds 32 registers of 32 bits. Reset clears every register and all four read outputs to zero.
- R2: Register number 0 always reads as zero. Writes to register 0 on any port are discarded.
- R3: When write ports 0 and 1 target the same register in one core cycle, the register takes the data of port 1.
- R4: When write port 2 targets the same register as port 0 or port 1 in one core cycle, the register takes the data of port 2.
- R5: A read whose register number matches an enabled write in the same core cycle returns the newly written data, on every one of the four read ports.
- R6: The read words for a core cycle's requests appear at the A edge that ends that core cycle. They do not change at the B edge that follows.
- R7: A write port whose enable is low leaves every register unchanged, whatever its address and data.
- R8: The four read ports use independent register numbers. Written values persist until overwritten.
- R9: Inputs are sampled only at the A edge, which is the first rising `clk2x` edge of each core cycle, counted from the first edge after reset release. Input changes between an A edge and the next B edge have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Double-rate clock; two periods per core cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 3 | Write enable per write port |
| wr_addr | input | 3x5 | Register number per write port |
| wr_data | input | 3x32 | Write data per write port |
| rd_addr | input | 4x5 | Register number per read port |
| rd_data | output | 4x32 | Read data per read port, one core cycle later |

## Verification
The embedded assertions check several properties on every cycle. The A/B sub-cycle alternates without a break, and the outputs never move at a B edge. Register 0 reads as zero on every physical read. The two physical write ports never target the same row on the same edge, and the port 2 forward path delivers the committed data. The port priorities, the discarding of disabled writes and the rejection of late input changes are visible only as final register contents. The directed scenarios cover these, along with agreement with a behavioural three-write, four-read model.

// File: rtl/rf_pkg.sv
package rf_pkg;
   // Core-level port counts and physical port counts of the pumped array
   localparam int RF_NWR = 3;
   localparam int RF_NRD = 4;
   localparam int RF_PHY_W = 2;
   localparam int RF_PHY_R = 2;

   // Which half of the core cycle the next clk2x edge belongs to
   typedef enum logic {
      SUB_A = 1'b0,
      SUB_B = 1'b1
   } sub_e;
endpackage

// File: rtl/rf_wr_arbiter.sv
// Drops a write when a higher-numbered port targets the same register.
module rf_wr_arbiter #(
   parameter int NP = 2,
   parameter int AW = 5
) (
   input  logic [NP-1:0]         en_i,
   input  logic [NP-1:0][AW-1:0] addr_i,
   output logic [NP-1:0]         en_o
);
   generate
      for (genvar i = 0; i < NP; i++) begin : g_port
         logic shadowed;
         always_comb begin
            shadowed = 1'b0;
            for (int j = i + 1; j < NP; j++) begin
               if (en_i[j] && (addr_i[j] == addr_i[i])) shadowed = 1'b1;
            end
         end
         assign en_o[i] = en_i[i] && !shadowed;
      end
   endgenerate
endmodule

// File: rtl/rf_storage.sv
// Register array with NWP write ports and NRP combinational read ports.
// Row 0 is hardwired to zero.
module rf_storage #(
   parameter int NREG     = 32,
   parameter int DW       = 32,
   parameter int NWP      = 2,
   parameter int NRP      = 2,
   parameter bit RESET_EN = 1'b1,
   localparam int AW      = $clog2(NREG)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NWP-1:0]         we_i,
   input  logic [NWP-1:0][AW-1:0] wa_i,
   input  logic [NWP-1:0][DW-1:0] wd_i,
   input  logic [NRP-1:0][AW-1:0] ra_i,
   output logic [NRP-1:0][DW-1:0] rd_o
);
   logic [NREG-1:0][DW-1:0] rows;

   assign rows[0] = '0;

   generate
      for (genvar g = 1; g < NREG; g++) begin : g_row
         logic [DW-1:0] q;
         logic [DW-1:0] d;
         logic          hit;
         always_comb begin
            d   = q;
            hit = 1'b0;
            for (int p = 0; p < NWP; p++) begin
               if (we_i[p] && (int'(wa_i[p]) == g)) begin
                  d   = wd_i[p];
                  hit = 1'b1;
               end
            end
         end
         if (RESET_EN) begin : g_rst
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   q <= '0;
               else if (hit) q <= d;
            end
         end else begin : g_norst
            always_ff @(posedge clk) begin
               if (hit) q <= d;
            end
         end
         assign rows[g] = q;
      end

      for (genvar r = 0; r < NRP; r++) begin : g_rd
         assign rd_o[r] = rows[ra_i[r]];
         // R2: a physical read of row 0 yields zero
         p_row0_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ra_i[r] == '0) |-> (rd_o[r] == '0));
      end

      for (genvar a = 0; a < NWP; a++) begin : g_wa
         for (genvar b = a + 1; b < NWP; b++) begin : g_wb
            // R3: the arbiter never lets two physical ports hit one row on one edge
            p_no_dup_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
               !(we_i[a] && we_i[b] && (wa_i[a] == wa_i[b])));
         end
      end
   endgenerate
endmodule

// File: rtl/rf_fwd.sv
// Forwards a write that commits on the same edge as a read is taken.
module rf_fwd #(
   parameter int AW = 5,
   parameter int DW = 32
) (
   input  logic [DW-1:0] arr_i,
   input  logic [AW-1:0] ra_i,
   input  logic          we_i,
   input  logic [AW-1:0] wa_i,
   input  logic [DW-1:0] wd_i,
   output logic [DW-1:0] rd_o
);
   logic match;
   assign match = we_i && (wa_i == ra_i) && (ra_i != '0);
   assign rd_o  = match ? wd_i : arr_i;
endmodule

// File: rtl/pumped_regfile.sv
module pumped_regfile
   import rf_pkg::*;
#(
   parameter int NREG     = 32,
   parameter int DW       = 32,
   parameter bit RESET_EN = 1'b1,
   localparam int AW      = $clog2(NREG)
) (
   input  logic                      clk2x,
   input  logic                      rst_n,
   input  logic [RF_NWR-1:0]         wr_en,
   input  logic [RF_NWR-1:0][AW-1:0] wr_addr,
   input  logic [RF_NWR-1:0][DW-1:0] wr_data,
   input  logic [RF_NRD-1:0][AW-1:0] rd_addr,
   output logic [RF_NRD-1:0][DW-1:0] rd_data
);
   localparam int HALF = RF_NRD / RF_PHY_R;

   generate
      if (NREG < 2 || (1 << AW) != NREG) begin : g_bad_depth
         $error("NREG must be a power of two and at least 2");
      end
      if (DW < 1) begin : g_bad_width
         $error("DW must be positive");
      end
      if (HALF != 2 || RF_NWR != RF_PHY_W + 1) begin : g_bad_ports
         $error("port counts do not fit a two-sub-cycle schedule");
      end
   endgenerate

   sub_e ph_q;

   // Requests held from the A edge for use later in the core cycle
   logic                      w2_en_q;
   logic [AW-1:0]             w2_addr_q;
   logic [DW-1:0]             w2_data_q;
   logic [RF_NRD-1:0][AW-1:0] ra_q;
   logic [RF_PHY_R-1:0][DW-1:0] hold_q;

   logic [RF_PHY_W-1:0]         a_en;
   logic [RF_PHY_W-1:0]         p_we;
   logic [RF_PHY_W-1:0][AW-1:0] p_wa;
   logic [RF_PHY_W-1:0][DW-1:0] p_wd;
   logic [RF_PHY_R-1:0][AW-1:0] p_ra;
   logic [RF_PHY_R-1:0][DW-1:0] p_rd;
   logic [RF_PHY_R-1:0][DW-1:0] fwd_rd;

   always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) ph_q <= SUB_A;
      else        ph_q <= (ph_q == SUB_A) ? SUB_B : SUB_A;
   end

   always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
         w2_en_q   <= 1'b0;
         w2_addr_q <= '0;
         w2_data_q <= '0;
         ra_q      <= '0;
      end else if (ph_q == SUB_A) begin
         w2_en_q   <= wr_en[RF_NWR-1];
         w2_addr_q <= wr_addr[RF_NWR-1];
         w2_data_q <= wr_data[RF_NWR-1];
         ra_q      <= rd_addr;
      end
   end

   // Priority between the two ports that share the A edge
   rf_wr_arbiter #(.NP(RF_PHY_W), .AW(AW)) u_arb (
      .en_i  (wr_en[RF_PHY_W-1:0]),
      .addr_i(wr_addr[RF_PHY_W-1:0]),
      .en_o  (a_en)
   );

   // Physical port schedule: A edge takes ports 0..1, B edge takes port 2 on lane 0
   generate
      for (genvar w = 0; w < RF_PHY_W; w++) begin : g_wsel
         if (w == 0) begin : g_lane0
            assign p_we[w] = (ph_q == SUB_A) ? a_en[w]       : w2_en_q;
            assign p_wa[w] = (ph_q == SUB_A) ? wr_addr[w]    : w2_addr_q;
            assign p_wd[w] = (ph_q == SUB_A) ? wr_data[w]    : w2_data_q;
         end else begin : g_laneN
            assign p_we[w] = (ph_q == SUB_A) ? a_en[w]       : 1'b0;
            assign p_wa[w] = wr_addr[w];
            assign p_wd[w] = wr_data[w];
         end
      end

      for (genvar r = 0; r < RF_PHY_R; r++) begin : g_rsel
         assign p_ra[r] = (ph_q == SUB_B) ? ra_q[r] : ra_q[RF_PHY_R + r];
      end
   endgenerate

   rf_storage #(
      .NREG    (NREG),
      .DW      (DW),
      .NWP     (RF_PHY_W),
      .NRP     (RF_PHY_R),
      .RESET_EN(RESET_EN)
   ) u_store (
      .clk  (clk2x),
      .rst_n(rst_n),
      .we_i (p_we),
      .wa_i (p_wa),
      .wd_i (p_wd),
      .ra_i (p_ra),
      .rd_o (p_rd)
   );

   generate
      for (genvar r = 0; r < RF_PHY_R; r++) begin : g_lo
         // Port 2 lands on the same B edge as the first read pair: forward it
         rf_fwd #(.AW(AW), .DW(DW)) u_fwd (
            .arr_i(p_rd[r]),
            .ra_i (ra_q[r]),
            .we_i (w2_en_q),
            .wa_i (w2_addr_q),
            .wd_i (w2_data_q),
            .rd_o (fwd_rd[r])
         );

         always_ff @(posedge clk2x or negedge rst_n) begin
            if (!rst_n)                hold_q[r] <= '0;
            else if (ph_q == SUB_B)    hold_q[r] <= fwd_rd[r];
         end

         always_ff @(posedge clk2x or negedge rst_n) begin
            if (!rst_n) begin
               rd_data[r]            <= '0;
               rd_data[RF_PHY_R + r] <= '0;
            end else if (ph_q == SUB_A) begin
               rd_data[r]            <= hold_q[r];
               rd_data[RF_PHY_R + r] <= p_rd[r];
            end
         end

         // R5: a port 2 write to the register read in the same core cycle is forwarded
         p_fwd_r5: assert property (@(posedge clk2x) disable iff (!rst_n)
            (ph_q == SUB_B && w2_en_q && w2_addr_q == ra_q[r] && ra_q[r] != '0)
            |=> (hold_q[r] == $past(w2_data_q)));

         // R2: register 0 on a late read pair yields zero at the output
         p_zero_out_r2: assert property (@(posedge clk2x) disable iff (!rst_n)
            (ph_q == SUB_A && ra_q[RF_PHY_R + r] == '0)
            |=> (rd_data[RF_PHY_R + r] == '0));
      end
   endgenerate

   // R9: sub-cycles alternate on every edge
   p_phase_alt_r9: assert property (@(posedge clk2x) disable iff (!rst_n)
      1'b1 |=> (ph_q != $past(ph_q)));

   // R6: outputs never change at a B edge
   p_out_hold_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
      (ph_q == SUB_B) |=> $stable(rd_data));
endmodule

// File: tb/pumped_regfile_tb.sv
`timescale 1ns/1ps
module pumped_regfile_tb;
   logic clk2x = 1'b0;
   logic rst_n = 1'b0;
   logic [2:0]       we;
   logic [2:0][4:0]  wa;
   logic [2:0][31:0] wd;
   logic [3:0][4:0]  ra;
   logic [3:0][31:0] rd;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   logic [31:0] model [32];
   logic [31:0] pend_exp [4];
   string       pend_tag;
   bit          pend_v = 1'b0;

   always #2 clk2x = ~clk2x;

   pumped_regfile u_dut (
      .clk2x  (clk2x),
      .rst_n  (rst_n),
      .wr_en  (we),
      .wr_addr(wa),
      .wr_data(wd),
      .rd_addr(ra),
      .rd_data(rd)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%08h exp=%08h t=%0t", tag, act, exp, $time);
      end
   endtask

   // One core cycle: drive, pass A and B edges, check the previous request.
   task automatic issue(input string tag, input bit glitch);
      logic [31:0] e [4];
      logic [3:0][31:0] snap;
      for (int w = 0; w < 3; w++)
         if (we[w] && wa[w] != 5'd0) model[wa[w]] = wd[w];
      for (int r = 0; r < 4; r++) e[r] = (ra[r] == 5'd0) ? 32'd0 : model[ra[r]];
      @(posedge clk2x); @(negedge clk2x);
      if (pend_v)
         for (int r = 0; r < 4; r++) chk(rd[r] === pend_exp[r], pend_tag, rd[r], pend_exp[r]);
      snap = rd;
      if (glitch) begin
         we = 3'b111;
         wa = {5'd1, 5'd1, 5'd1};
         wd = {32'hBAD0_0002, 32'hBAD0_0001, 32'hBAD0_0000};
         ra = '0;
      end
      @(posedge clk2x); @(negedge clk2x);
      if (pend_v)
         for (int r = 0; r < 4; r++) chk(rd[r] === snap[r], "R6 hold over B edge", rd[r], snap[r]);
      for (int r = 0; r < 4; r++) pend_exp[r] = e[r];
      pend_tag = tag;
      pend_v = 1'b1;
   endtask

   task automatic idle_read(input logic [4:0] a0, a1, a2, a3, input string tag);
      we = '0; wa = '0; wd = '0;
      ra = {a3, a2, a1, a0};
      issue(tag, 1'b0);
   endtask

   task automatic flush();
      idle_read(5'd0, 5'd0, 5'd0, 5'd0, "R2 flush");
   endtask

   task automatic t_reset();
      for (int r = 0; r < 4; r++) chk(rd[r] === 32'd0, "R1 reset output", rd[r], 32'd0);
      idle_read(5'd1, 5'd2, 5'd30, 5'd31, "R1 cleared rows");
      flush();
   endtask

   task automatic t_basic();
      we = 3'b111; wa = {5'd7, 5'd6, 5'd5};
      wd = {32'h7777_0007, 32'h6666_0006, 32'h5555_0005};
      ra = '0;
      issue("R8 write", 1'b0);
      idle_read(5'd7, 5'd5, 5'd0, 5'd6, "R8 independent reads");
      idle_read(5'd6, 5'd6, 5'd7, 5'd5, "R8 persist");
      flush();
   endtask

   task automatic t_zero();
      we = 3'b111; wa = '0; wd = {32'hFFFF_FFFF, 32'h1234_5678, 32'hDEAD_BEEF};
      ra = '0;
      issue("R2 same cycle", 1'b0);
      idle_read(5'd0, 5'd0, 5'd0, 5'd0, "R2 after write");
      flush();
   endtask

   task automatic t_prio01();
      we = 3'b011; wa = {5'd0, 5'd9, 5'd9}; wd = {32'd0, 32'hAAAA_0001, 32'h5555_0000};
      ra = {5'd9, 5'd9, 5'd9, 5'd9};
      issue("R3 port1 wins same cycle", 1'b0);
      idle_read(5'd9, 5'd0, 5'd9, 5'd0, "R3 port1 wins");
      flush();
   endtask

   task automatic t_prio2();
      we = 3'b111; wa = {5'd12, 5'd12, 5'd12};
      wd = {32'hCCCC_0002, 32'hBBBB_0001, 32'hAAAA_0000};
      ra = {5'd12, 5'd12, 5'd12, 5'd12};
      issue("R4 port2 wins same cycle", 1'b0);
      we = 3'b101; wa = {5'd13, 5'd0, 5'd13}; wd = {32'h1313_0002, 32'd0, 32'h1313_0000};
      ra = {5'd13, 5'd12, 5'd13, 5'd12};
      issue("R4 port2 over port0", 1'b0);
      flush();
   endtask

   task automatic t_bypass();
      we = 3'b111; wa = {5'd22, 5'd21, 5'd20};
      wd = {32'h2222_2222, 32'h2121_2121, 32'h2020_2020};
      ra = {5'd20, 5'd22, 5'd21, 5'd20};
      issue("R5 read own write", 1'b0);
      wa = {5'd21, 5'd20, 5'd22}; wd = {32'h0000_0A21, 32'h0000_0A20, 32'h0000_0A22};
      ra = {5'd21, 5'd20, 5'd22, 5'd21};
      issue("R5 read own write swapped", 1'b0);
      flush();
   endtask

   task automatic t_disabled();
      we = 3'b001; wa = {5'd0, 5'd0, 5'd3}; wd = {32'd0, 32'd0, 32'h0303_0303};
      ra = '0;
      issue("R7 preload", 1'b0);
      we = 3'b000; wa = {5'd3, 5'd3, 5'd3}; wd = {32'hEEEE_0002, 32'hEEEE_0001, 32'hEEEE_0000};
      ra = {5'd3, 5'd3, 5'd3, 5'd3};
      issue("R7 disabled same cycle", 1'b0);
      idle_read(5'd3, 5'd3, 5'd3, 5'd3, "R7 disabled after");
      flush();
   endtask

   task automatic t_phase();
      we = 3'b000; wa = '0; wd = '0;
      ra = {5'd1, 5'd1, 5'd1, 5'd1};
      issue("R9 late change ignored", 1'b1);
      idle_read(5'd1, 5'd1, 5'd1, 5'd1, "R9 row untouched");
      flush();
   endtask

   task automatic t_random();
      for (int n = 0; n < 400; n++) begin
         for (int w = 0; w < 3; w++) begin
            we[w] = $urandom_range(0, 3) != 0;
            wa[w] = 5'($urandom_range(0, 7) + (n % 4) * 8);
            wd[w] = $urandom;
         end
         for (int r = 0; r < 4; r++) ra[r] = 5'($urandom_range(0, 31));
         issue("R8 random traffic", 1'b0);
      end
      flush();
   endtask

   initial begin
      for (int i = 0; i < 32; i++) model[i] = 32'd0;
      we = '0; wa = '0; wd = '0; ra = '0;
      repeat (3) @(negedge clk2x);
      t_reset_pre: begin
         for (int r = 0; r < 4; r++) chk(rd[r] === 32'd0, "R1 in reset", rd[r], 32'd0);
      end
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_zero();
      t_prio01();
      t_prio2();
      t_bypass();
      t_disabled();
      t_phase();
      t_random();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #400000;
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired t=%0t", $time);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule